// File: doc/BRIEF.md
# Edge-Selectable Wakeup Interrupt Controller

This block watches a group of external wakeup pins and a smaller group of external interrupt-request pins. Every pin is brought into the clock domain through a two-flop synchronizer. A third registered copy of the pin serves as edge history. Each pin has its own polarity bit that chooses rising or falling sensing. A wakeup pin records an edge only when its pin-mode bit hands it to the wakeup function. A recorded edge sets a sticky per-pin flag, and software clears that flag by writing a 0 to its bit.

The wakeup flags are ORed into one request. The request is gated by a group enable and by a global CPU mask. While the request is active, the block presents the single shared vector number 9. The handler must therefore read the flag register to find which pin fired. An acknowledge pulse from the CPU sets the global mask bit again. The interrupt-request pins have their own polarity register and flag register, and their flags are brought out directly for priority logic outside the block. All registers sit behind a small synchronous register bus that returns read data one cycle after the access.

Top module: `wkup_irq_ctrl`

## Requirements
- R1: The wakeup polarity register (address 0) resets to 0x00. Bit n = 0 makes wakeup pin n sense falling edges, and bit n = 1 makes it sense rising edges.
- R2: A sensed edge on wakeup pin n sets wakeup flag n (address 3) only while pin-mode bit n (address 1) is 1. The pin-mode register resets to 0x00.
- R3: Each pin transition sets its flag at most once. The flag bit becomes 1 on the third rising clock edge that samples the new pin level. A level held steady never sets the flag again.
- R4: A bus write to a flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. When a new edge sets a bit on the same clock edge as a write that clears it, the bit ends up 1.
- R5: The control register (address 2) holds bit 0 = group enable, which resets to 0, and bit 1 = global mask, which resets to 1. A pulse on int_ack sets the mask to 1, and this takes priority over a bus write on the same edge.
- R6: wake_req is a register. On each clock edge it loads (any wakeup flag is 1) AND enable AND NOT mask, using the values the registers held before that edge.
- R7: wake_vec is 9 while wake_req is 1 and 0 otherwise.
- R8: A write to a polarity register suppresses edge detection during the following cycle, for the bits whose value changed. A polarity change on its own therefore never sets a flag.
- R9: The interrupt-request pins use their own polarity register (address 4, reset 0x0, same encoding as R1) and their own flag register (address 5, cleared as in R4). No pin-mode gating applies to these pins. irq_pend shows the flag register.
- R10: A read (bus_sel = 1, bus_we = 0) returns the addressed register on bus_rdata after the next clock edge. Unused bits and unused addresses read 0. bus_rdata resets to 0 and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin | input | NWAKE | Asynchronous wakeup pins |
| irq_pin | input | NIRQ | Asynchronous interrupt-request pins |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| int_ack | input | 1 | CPU accepted the wakeup interrupt |
| wake_req | output | 1 | Shared wakeup interrupt request |
| wake_vec | output | DW | Vector number, 9 while requesting |
| irq_pend | output | NIRQ | Interrupt-request pin flags |

## Verification
The assertions assume that bus_sel, bus_we, bus_addr, bus_wdata and int_ack are driven synchronously and are stable around the rising edge. Only the pins may change at any time. The assertions also assume that int_ack is a single-cycle pulse. The bench meets these assumptions by changing every input on the falling clock edge, which the synchronizers see the same way as a real asynchronous input. Pin edges and polarity writes are allowed to collide in the randomized phase, because the suppression window of R8 is part of the reference model.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_WPOL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_WMODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WFLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_IPOL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IFLAG = 3'd5;
  localparam int WAKE_VECTOR = 9;
endpackage

// File: rtl/wk_edge_catch.sv
module wk_edge_catch #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] guard,
  output logic [W-1:0] hit
);
  localparam int LEN = SYNC + 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [LEN-1:0] sh;
    logic now_v, old_v;

    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[LEN-2:0], pin_in[i]};
    end

    assign now_v  = sh[SYNC-1];
    assign old_v  = sh[SYNC];
    assign hit[i] = !guard[i] && (pol[i] ? (now_v && !old_v) : (!now_v && old_v));
  end
endmodule

// File: rtl/wk_flag_bank.sv
module wk_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] flags
);
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we ? ~clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_mask) | set_in;
  end

  // R3: a flag only rises when a set was presented on the edge before
  assert_set_only_R3: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~$past(flags)) & ~$past(set_in)) == '0);

  // R4: every presented set lands, even against a clearing write
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (|set_in) |=> ((flags & $past(set_in)) == $past(set_in)));
endmodule

// File: rtl/wkup_irq_ctrl.sv
module wkup_irq_ctrl
  import wkup_pkg::*;
#(
  parameter int NWAKE = 8,
  parameter int NIRQ  = 4,
  parameter int DW    = 8,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NWAKE-1:0]  wake_pin,
  input  logic [NIRQ-1:0]   irq_pin,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              int_ack,
  output logic              wake_req,
  output logic [DW-1:0]     wake_vec,
  output logic [NIRQ-1:0]   irq_pend
);
  localparam logic [DW-1:0] VEC = DW'(WAKE_VECTOR);

  logic [NWAKE-1:0] wpol_q, wmode_q, wguard_q, whit, wset, wflags;
  logic [NIRQ-1:0]  ipol_q, iguard_q, ihit, iflags;
  logic             en_q, mask_q, req_q;
  logic [DW-1:0]    vec_q, rd_q, rd_mux;
  logic             wr, rd;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  wk_edge_catch #(.W(NWAKE), .SYNC(SYNC)) u_wake_edge (
    .clk(clk), .rst(rst), .pin_in(wake_pin), .pol(wpol_q),
    .guard(wguard_q), .hit(whit));

  wk_edge_catch #(.W(NIRQ), .SYNC(SYNC)) u_irq_edge (
    .clk(clk), .rst(rst), .pin_in(irq_pin), .pol(ipol_q),
    .guard(iguard_q), .hit(ihit));

  assign wset = whit & wmode_q;

  wk_flag_bank #(.W(NWAKE)) u_wake_flags (
    .clk(clk), .rst(rst), .set_in(wset),
    .clr_we(wr && bus_addr == A_WFLAG), .clr_data(bus_wdata[NWAKE-1:0]),
    .flags(wflags));

  wk_flag_bank #(.W(NIRQ)) u_irq_flags (
    .clk(clk), .rst(rst), .set_in(ihit),
    .clr_we(wr && bus_addr == A_IFLAG), .clr_data(bus_wdata[NIRQ-1:0]),
    .flags(iflags));

  // configuration registers and polarity-change guards
  always_ff @(posedge clk) begin
    if (rst) begin
      wpol_q   <= '0;
      wmode_q  <= '0;
      ipol_q   <= '0;
      wguard_q <= '0;
      iguard_q <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b1;
    end else begin
      wguard_q <= '0;
      iguard_q <= '0;
      if (wr) begin
        case (bus_addr)
          A_WPOL: begin
            wguard_q <= bus_wdata[NWAKE-1:0] ^ wpol_q;
            wpol_q   <= bus_wdata[NWAKE-1:0];
          end
          A_WMODE: wmode_q <= bus_wdata[NWAKE-1:0];
          A_CTRL: begin
            en_q   <= bus_wdata[0];
            mask_q <= bus_wdata[1];
          end
          A_IPOL: begin
            iguard_q <= bus_wdata[NIRQ-1:0] ^ ipol_q;
            ipol_q   <= bus_wdata[NIRQ-1:0];
          end
          default: ;
        endcase
      end
      if (int_ack) mask_q <= 1'b1;
    end
  end

  // request and vector
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= (|wflags) && en_q && !mask_q;
      vec_q <= ((|wflags) && en_q && !mask_q) ? VEC : '0;
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_WPOL:  rd_mux[NWAKE-1:0] = wpol_q;
      A_WMODE: rd_mux[NWAKE-1:0] = wmode_q;
      A_CTRL:  rd_mux[1:0]       = {mask_q, en_q};
      A_WFLAG: rd_mux[NWAKE-1:0] = wflags;
      A_IPOL:  rd_mux[NIRQ-1:0]  = ipol_q;
      A_IFLAG: rd_mux[NIRQ-1:0]  = iflags;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (rd) rd_q <= rd_mux;
  end

  assign bus_rdata = rd_q;
  assign wake_req  = req_q;
  assign wake_vec  = vec_q;
  assign irq_pend  = iflags;

  // R5: an accepted interrupt leaves the mask set
  assert_ack_masks_R5: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> mask_q);

  // R6: a request implies enable, no mask and a pending flag one edge earlier
  assert_req_gated_R6: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> ($past(en_q) && !$past(mask_q) && (|$past(wflags))));

  // R7: vector follows the request
  assert_vec_match_R7: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (wake_vec == VEC));
  assert_vec_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !wake_req |-> (wake_vec == '0));

  // R8: no flag rises on a bit whose polarity just changed
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    ((wflags & ~$past(wflags)) & $past(wguard_q)) == '0);
endmodule

// File: tb/wkup_irq_ctrl_test.sv
module wkup_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wake_pin = '0;
  logic [3:0] irq_pin = '0;
  logic       bus_sel = 1'b0, bus_we = 1'b0, int_ack = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, wake_vec;
  logic       wake_req;
  logic [3:0] irq_pend;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wkup_irq_ctrl uut (
    .clk(clk), .rst(rst), .wake_pin(wake_pin), .irq_pin(irq_pin),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_ack(int_ack),
    .wake_req(wake_req), .wake_vec(wake_vec), .irq_pend(irq_pend));

  // behavioural reference model
  logic [7:0] m_wpol, m_wmode, m_wflag, m_wguard, m_rd, m_vec;
  logic [3:0] m_ipol, m_iflag, m_iguard;
  logic       m_en, m_mask, m_req;
  logic [7:0] wq[$];
  logic [3:0] iq[$];

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_wpol;
      3'd1: return m_wmode;
      3'd2: return {6'b0, m_mask, m_en};
      3'd3: return m_wflag;
      3'd4: return {4'b0, m_ipol};
      3'd5: return {4'b0, m_iflag};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_wpol = 0; m_wmode = 0; m_wflag = 0; m_wguard = 0; m_rd = 0; m_vec = 0;
      m_ipol = 0; m_iflag = 0; m_iguard = 0; m_en = 0; m_mask = 1; m_req = 0;
      wq = '{8'h0, 8'h0, 8'h0};
      iq = '{4'h0, 4'h0, 4'h0};
    end else begin
      logic [7:0] wn, wo, wset, wclr, n_wflag, n_wguard, n_rd;
      logic [3:0] in_, io, iset, iclr, n_iflag, n_iguard;
      logic       wr, n_req;
      wn = wq[1]; wo = wq[2];
      in_ = iq[1]; io = iq[2];
      wr = bus_sel && bus_we;
      wset = ~m_wguard & ((m_wpol & wn & ~wo) | (~m_wpol & ~wn & wo)) & m_wmode;
      iset = ~m_iguard & ((m_ipol & in_ & ~io) | (~m_ipol & ~in_ & io));
      wclr = (wr && bus_addr == 3'd3) ? ~bus_wdata : 8'h00;
      iclr = (wr && bus_addr == 3'd5) ? ~bus_wdata[3:0] : 4'h0;
      n_wflag = (m_wflag & ~wclr) | wset;
      n_iflag = (m_iflag & ~iclr) | iset;
      n_req = (m_wflag != 0) && m_en && !m_mask;
      n_rd = (bus_sel && !bus_we) ? model_read(bus_addr) : m_rd;
      n_wguard = (wr && bus_addr == 3'd0) ? (bus_wdata ^ m_wpol) : 8'h00;
      n_iguard = (wr && bus_addr == 3'd4) ? (bus_wdata[3:0] ^ m_ipol) : 4'h0;
      if (wr) begin
        if (bus_addr == 3'd0) m_wpol = bus_wdata;
        if (bus_addr == 3'd1) m_wmode = bus_wdata;
        if (bus_addr == 3'd2) begin m_en = bus_wdata[0]; m_mask = bus_wdata[1]; end
        if (bus_addr == 3'd4) m_ipol = bus_wdata[3:0];
      end
      if (int_ack) m_mask = 1'b1;
      m_wflag = n_wflag; m_iflag = n_iflag; m_req = n_req;
      m_vec = n_req ? 8'd9 : 8'd0;
      m_rd = n_rd; m_wguard = n_wguard; m_iguard = n_iguard;
      wq.push_front(wake_pin); void'(wq.pop_back());
      iq.push_front(irq_pin);  void'(iq.pop_back());
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R6 wake_req", {7'b0, wake_req}, {7'b0, m_req});
      check("R7 wake_vec", wake_vec, m_vec);
      check("R9 irq_pend", {4'b0, irq_pend}, {4'b0, m_iflag});
      check("R10 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    // reset state
    read_chk(3'd0, 8'h00, "R1 reset polarity");
    read_chk(3'd1, 8'h00, "R2 reset mode");
    read_chk(3'd2, 8'h02, "R5 reset control");
    read_chk(3'd3, 8'h00, "R10 reset flags");
    read_chk(3'd7, 8'h00, "R10 unused address");
    // mode gating with falling sense
    bus_write(3'd1, 8'h0F);
    wake_pin = 8'hFF; idle(5);
    read_chk(3'd3, 8'h00, "R1 rising ignored under falling sense");
    wake_pin = 8'h00; idle(5);
    read_chk(3'd3, 8'h0F, "R2 falling edges gated by mode");
    // clear semantics
    bus_write(3'd3, 8'hFE); idle(1);
    read_chk(3'd3, 8'h0E, "R4 write zero clears");
    bus_write(3'd3, 8'hFF); idle(1);
    read_chk(3'd3, 8'h0E, "R4 write one keeps");
    // polarity change alone
    bus_write(3'd0, 8'hFF); idle(3);
    read_chk(3'd3, 8'h0E, "R8 polarity write no flag");
    wake_pin = 8'h01; idle(5);
    read_chk(3'd3, 8'h0F, "R1 rising sense sets bit0");
    bus_write(3'd3, 8'h00); idle(4);
    read_chk(3'd3, 8'h00, "R3 held level sets no second flag");
    // request path
    wake_pin = 8'h03; idle(5);
    bus_write(3'd2, 8'h01); idle(2);
    check("R6 request raised", {7'b0, wake_req}, 8'h01);
    check("R7 vector nine", wake_vec, 8'd9);
    int_ack = 1; @(negedge clk); int_ack = 0; idle(2);
    check("R5 ack drops request", {7'b0, wake_req}, 8'h00);
    read_chk(3'd2, 8'h03, "R5 mask set by ack");
    // set versus clear on the same edge
    wake_pin = 8'h07;
    idle(2);
    bus_write(3'd3, 8'h00); idle(1);
    read_chk(3'd3, 8'h04, "R4 set wins over clear");
    // IRQ pins
    bus_write(3'd4, 8'h01);
    irq_pin = 4'hF; idle(5);
    check("R9 irq rising bit0", {4'b0, irq_pend}, 8'h01);
    irq_pin = 4'h0; idle(5);
    read_chk(3'd5, 8'h0F, "R9 irq falling bits");
    bus_write(3'd5, 8'h00); idle(1);
    check("R9 irq cleared", {4'b0, irq_pend}, 8'h00);
    // randomized phase against the model
    bus_write(3'd1, 8'hA7);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) wake_pin = 8'($urandom);
      if ($urandom_range(0, 5) == 0) irq_pin = 4'($urandom);
      int_ack = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 4) == 0) begin
        bus_sel = 1; bus_we = 1'($urandom); bus_addr = 3'($urandom_range(0, 6));
        bus_wdata = 8'($urandom);
      end else begin
        bus_sel = 0; bus_we = 0;
      end
      @(negedge clk);
    end
    bus_sel = 0; bus_we = 0; int_ack = 0;
    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule